// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer with three word registers: control, reload and live count. A peripheral clock first drives an 8-bit prescaler. The prescaler output then passes through a fixed divider, selectable from 16, 32, 64 or 128, and each divided tick decrements a 16-bit counter while the timer is enabled.

Software services the watchdog by writing the count register before it runs out. If it is not serviced, the first tick that finds the counter at zero is an expiry. On expiry the block drives a one-cycle interrupt pulse, a one-cycle system reset pulse, or both, as the two enable bits select. It then reloads the counter from the reload register and keeps running.

All writes are single-cycle strobes with a byte address. Read data is registered and appears one clock after the address is presented.

Top module: `wdog_timer`

## Requirements
- R1: Control sits at byte offset 0x0, reload at 0x4 and count at 0x8. Reading returns the register one clock after the address is applied. Control reads back only its defined bits, so a write of all ones reads 0x0000FF3D. Reload and count read back their low 16 bits.
- R2: After reset, control reads 0 (timer disabled), reload and count read 0x8000, and both pulse outputs are low.
- R3: Control bit 5 is the run enable. While it is 0 the count holds its value and no pulse is produced, even with both pulse enables set.
- R4: The tick period is (P+1)*F clocks, where P is control bits [15:8] and F = 16 << S, with S being control bits [4:3] (0:16, 1:32, 2:64, 3:128).
- R5: An expiry is a tick that finds the count at zero. A count C loaded before enabling gives the first pulse (C+1)*(P+1)*F clocks after the clock edge that writes the enable.
- R6: On expiry, irq_pulse is high for exactly one clock, and only if control bit 2 is set.
- R7: On expiry, reset_pulse is high for exactly one clock, and only if control bit 0 is set.
- R8: An expiry reloads the count from the reload register, so later expiries come every (N+1)*(P+1)*F clocks for a reload value N.
- R9: A count write takes effect on the next clock and wins over a coincident tick. It does not disturb the prescaler phase, so it postpones expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_pulse | output | 1 | One-cycle interrupt on expiry |
| reset_pulse | output | 1 | One-cycle system reset request on expiry |

## Verification
The hardest behaviour to reach from the ports is the exact timing of an expiry. That timing depends on the prescaler and the divider phase, on the counter value, and on a service write that lands in the middle of a tick interval.

The bench clears the dividers by disabling the timer, then loads the count and reload. It then enables every prescaler/divider pairing in the small range P=0..3, cycling through the three pulse-enable combinations. For each pairing it counts clock edges to the first and second pulses and compares them with the arithmetic period.

A separate run writes the count 41 edges after enabling. The next expiry must then land at the tick phase the bench predicts, not at the original one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // byte offsets of the three word registers
  localparam int OFS_CTRL   = 'h0;
  localparam int OFS_RELOAD = 'h4;
  localparam int OFS_COUNT  = 'h8;
  // control field positions
  localparam int RST_EN_BIT = 0;
  localparam int IRQ_EN_BIT = 2;
  localparam int SEL_LSB    = 3;
  localparam int RUN_BIT    = 5;
  localparam int PRE_LSB    = 8;
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int PRE_W         = 8,
  parameter int SEL_W         = 2,
  parameter int DIV_BASE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int MAX_SEL = (1 << SEL_W) - 1;
  localparam int DIV_W   = DIV_BASE_LOG2 + MAX_SEL;

  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;
  logic [SEL_W-1:0] sel_gap;
  logic             pre_hit;
  logic             div_hit;

  always_comb begin
    sel_gap  = SEL_W'(MAX_SEL) - sel;
    div_last = {DIV_W{1'b1}} >> sel_gap;
    pre_hit  = (pre_cnt >= pre);
    div_hit  = (div_cnt >= div_last);
    tick     = run && pre_hit && div_hit;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_hit) begin
      pre_cnt <= '0;
      div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // divide factor is at least 16, so ticks are never back to back
  AST_TICK_SPARSE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R4
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int               ADDR_W     = 4,
  parameter int               DATA_W     = 32,
  parameter int               PRE_W      = 8,
  parameter int               SEL_W      = 2,
  parameter int               CNT_W      = 16,
  parameter logic [CNT_W-1:0] RESET_LOAD = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  cnt_now,
  output logic [PRE_W-1:0]  pre,
  output logic              run,
  output logic [SEL_W-1:0]  sel,
  output logic              irq_en,
  output logic              rst_en,
  output logic [CNT_W-1:0]  reload,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wr_val,
  output logic [DATA_W-1:0] rd_data
);
  logic              hit_ctrl, hit_reload, hit_count;
  logic [DATA_W-1:0] rd_next;
  logic              unused_wr;

  assign hit_ctrl   = (addr == ADDR_W'(OFS_CTRL));
  assign hit_reload = (addr == ADDR_W'(OFS_RELOAD));
  assign hit_count  = (addr == ADDR_W'(OFS_COUNT));
  assign cnt_wr     = wr_en && hit_count;
  assign cnt_wr_val = wr_data[CNT_W-1:0];
  assign unused_wr  = ^wr_data;

  always_comb begin
    rd_next = '0;
    if (hit_ctrl) begin
      rd_next[PRE_LSB +: PRE_W] = pre;
      rd_next[SEL_LSB +: SEL_W] = sel;
      rd_next[RUN_BIT]          = run;
      rd_next[IRQ_EN_BIT]       = irq_en;
      rd_next[RST_EN_BIT]       = rst_en;
    end else if (hit_reload) begin
      rd_next[CNT_W-1:0] = reload;
    end else if (hit_count) begin
      rd_next[CNT_W-1:0] = cnt_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre     <= '0;
      run     <= 1'b0;
      sel     <= '0;
      irq_en  <= 1'b0;
      rst_en  <= 1'b0;
      reload  <= RESET_LOAD;
      rd_data <= '0;
    end else begin
      if (wr_en && hit_ctrl) begin
        pre    <= wr_data[PRE_LSB +: PRE_W];
        sel    <= wr_data[SEL_LSB +: SEL_W];
        run    <= wr_data[RUN_BIT];
        irq_en <= wr_data[IRQ_EN_BIT];
        rst_en <= wr_data[RST_EN_BIT];
      end
      if (wr_en && hit_reload) reload <= wr_data[CNT_W-1:0];
      rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int               CNT_W      = 16,
  parameter logic [CNT_W-1:0] RESET_LOAD = 16'h8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wr_val,
  input  logic [CNT_W-1:0] reload,
  input  logic             irq_en,
  input  logic             rst_en,
  output logic [CNT_W-1:0] cnt,
  output logic             irq_pulse,
  output logic             reset_pulse
);
  logic expire;
  assign expire = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= RESET_LOAD;
      irq_pulse   <= 1'b0;
      reset_pulse <= 1'b0;
    end else begin
      irq_pulse   <= expire && irq_en;
      reset_pulse <= expire && rst_en;
      if (cnt_wr)      cnt <= cnt_wr_val;
      else if (expire) cnt <= reload;
      else if (tick)   cnt <= cnt - 1'b1;
    end
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse); // R6
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    reset_pulse |=> !reset_pulse); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(irq_en)); // R6
  AST_RST_GATED: assert property (@(posedge clk) disable iff (rst)
    reset_pulse |-> $past(rst_en)); // R7
  AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == '0 && !cnt_wr) |=> cnt == $past(reload)); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> cnt == $past(cnt_wr_val)); // R9
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int               ADDR_W        = 4,
  parameter int               DATA_W        = 32,
  parameter int               PRE_W         = 8,
  parameter int               SEL_W         = 2,
  parameter int               DIV_BASE_LOG2 = 4,
  parameter int               CNT_W         = 16,
  parameter logic [CNT_W-1:0] RESET_LOAD    = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_pulse,
  output logic              reset_pulse
);
  logic [PRE_W-1:0] pre;
  logic [SEL_W-1:0] sel;
  logic             run, irq_en, rst_en, tick, cnt_wr;
  logic [CNT_W-1:0] reload, cnt_wr_val, cnt;

  wdog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W), .SEL_W(SEL_W),
    .CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .cnt_now(cnt), .pre(pre), .run(run), .sel(sel), .irq_en(irq_en),
    .rst_en(rst_en), .reload(reload), .cnt_wr(cnt_wr),
    .cnt_wr_val(cnt_wr_val), .rd_data(rd_data)
  );

  wdog_tick #(
    .PRE_W(PRE_W), .SEL_W(SEL_W), .DIV_BASE_LOG2(DIV_BASE_LOG2)
  ) u_tick (
    .clk(clk), .rst(rst), .run(run), .pre(pre), .sel(sel), .tick(tick)
  );

  wdog_count #(
    .CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)
  ) u_count (
    .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr),
    .cnt_wr_val(cnt_wr_val), .reload(reload), .irq_en(irq_en),
    .rst_en(rst_en), .cnt(cnt), .irq_pulse(irq_pulse),
    .reset_pulse(reset_pulse)
  );

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt)); // R3
  AST_NO_PULSE_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run |=> !(irq_pulse || reset_pulse)); // R3
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_pulse, reset_pulse;
  int          n_checks = 0;
  int          n_fail = 0;

  wdog_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_pulse(irq_pulse), .reset_pulse(reset_pulse)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called away from a clock edge; the write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  // counts rising edges until a pulse is seen (sampled at the falling edge)
  task automatic wait_pulse(input int limit, output int k);
    k = 0;
    while (k <= limit) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (irq_pulse || reset_pulse) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k, k2, t, c, n, m, ie, re, seen;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R2 reset state
    check("R2 pulses", {30'd0, irq_pulse, reset_pulse}, 32'd0);
    rd(4'h0, v); check("R2 ctrl", v, 32'h0);
    rd(4'h4, v); check("R2 reload", v, 32'h8000);
    rd(4'h8, v); check("R2 count", v, 32'h8000);

    // R1 decode and masking
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, v); check("R1 ctrl mask", v, 32'h0000_FF3D);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h5555_ABCD); rd(4'h4, v); check("R1 reload", v, 32'h0000_ABCD);
    wr(4'h8, 32'hFFFF_1234); rd(4'h8, v); check("R1 count", v, 32'h0000_1234);

    // R3 stopped timer holds count even with both pulse enables
    wr(4'h8, 32'h00AA); wr(4'h0, 32'h0005);
    seen = 0;
    repeat (100) begin @(negedge clk); if (irq_pulse || reset_pulse) seen = 1; end
    check("R3 no pulse stopped", seen, 0);
    rd(4'h8, v); check("R3 count held", v, 32'h00AA);

    // R4 R5 R6 R7 R8 sweep over prescaler 0..3 and all divide selects
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 4; s++) begin
        t = (p + 1) * (16 << s);
        c = p; n = s + 1; m = (p + s) % 3;
        ie = (m != 1) ? 1 : 0; re = (m != 0) ? 1 : 0;
        wr(4'h0, 32'h0);
        wr(4'h4, n); wr(4'h8, c);
        wr(4'h0, (p << 8) | (1 << 5) | (s << 3) | (ie << 2) | re);
        addr = 4'h8;
        wait_pulse((c + 1) * t + 4, k);
        check("R5 R4 first expiry edges", k, (c + 1) * t);
        check("R6 irq gated", irq_pulse, ie);
        check("R7 reset gated", reset_pulse, re);
        @(posedge clk); @(negedge clk);
        check("R6 R7 one-cycle pulse", {irq_pulse, reset_pulse}, 0);
        check("R8 reloaded count", rd_data, n);
        wait_pulse((n + 1) * t + 4, k2);
        check("R8 period after reload", k2 + 1, (n + 1) * t);
      end
    end

    // R9 service write postpones expiry (P=0, F=16, irq only)
    wr(4'h0, 32'h0); wr(4'h4, 32'd3); wr(4'h8, 32'd3);
    wr(4'h0, 32'h0024);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq_pulse) seen = 1;
    end
    check("R9 no early pulse", seen, 0);
    wr(4'h8, 32'd3);
    wait_pulse(100, k2);
    check("R9 postponed expiry edge", 41 + k2, 96);
    wr(4'h0, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule